// File: doc/BRIEF.md
# Overflow-Trapping Adder with Exception Redirect

This block is the add-and-redirect slice of a 32-bit load/store processor's execute and fetch control. It adds two operands and, when asked for a trapping add, checks for two's-complement overflow. Overflow is judged from the operand and result signs. A carry out of the top bit is never used for this. When an overflow trap is taken, the block cancels the register write and steers the next program counter to a fixed handler vector. On the following clock edge it stores the faulting instruction's own address in an exception PC register.

A return-from-exception request loads a target supplied by the caller. Software resumes after the faulting instruction by supplying the saved exception PC plus 4. When neither a trap nor a return is active, the next PC is the current address plus 4.

All inputs are plain, unhandshaked control and data pins, sampled every cycle. The block has no stall path, so there is no back-pressure: an add presented with its valid strobe is always consumed in that cycle. The sum, the write-enable and the next PC are combinational. Only the exception PC is registered.

Top module: `ovf_trap_unit`

## Requirements
- R1: `sum` equals `(op_a + op_b) mod 2^32` in the same cycle, whatever the values of `trap_en` and `add_valid`.
- R2: Overflow is flagged only when bit 31 of `op_a` equals bit 31 of `op_b` and bit 31 of `sum` differs from them. A trap is taken when `add_valid`=1, `trap_en`=1 and overflow is flagged.
- R3: A carry out of bit 31 does not by itself cause a trap. Examples: 0xFFFFFFFF+1 and 0x80000000+0x7FFFFFFF do not trap.
- R4: `wr_en` is 1 exactly when `add_valid`=1 and no trap is taken. With `add_valid`=0, `wr_en` is 0.
- R5: With `trap_en`=0 (non-trapping add), no trap is ever taken and `wr_en` follows `add_valid`.
- R6: In a cycle where a trap is taken, `next_pc` is 0x80000180.
- R7: At the clock edge that ends a trap cycle, `epc` takes the value of `inst_addr` from that cycle, without adding 4.
- R8: `epc` resets to 0 and keeps its value across every edge that does not end a trap cycle.
- R9: With `eret_req`=1 and no trap, `next_pc` equals `eret_target`.
- R10: With no trap and `eret_req`=0, `next_pc` equals `inst_addr + 4`.
- R11: When a trap and `eret_req` occur in the same cycle, the trap wins: `next_pc` is 0x80000180 and `epc` captures `inst_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| add_valid | input | 1 | An add is being executed this cycle |
| trap_en | input | 1 | 1 selects a trapping signed add, 0 selects a non-trapping add |
| inst_addr | input | 32 | Address of the current instruction |
| eret_req | input | 1 | Request to return from the exception handler |
| eret_target | input | 32 | PC to load on a return request |
| sum | output | 32 | Result of the addition |
| wr_en | output | 1 | Destination register write-enable |
| next_pc | output | 32 | Address of the next instruction to fetch |
| epc | output | 32 | Exception PC: address of the last faulting add |

## Verification
The assertions treat a trap as `add_valid && trap_en && !wr_en`. They therefore assume that `wr_en` is observed only in cycles with a defined add, and that the inputs are stable around the sampling edge. The bench changes the inputs only on falling edges and holds them through the next rising edge, so every assertion sees settled values. The return target is always derived from the `epc` port, not computed inside the block. The stimulus therefore models software returning to the saved PC plus 4, and the block's behaviour does not depend on that choice.

// File: rtl/ovf_trap_pkg.sv
package ovf_trap_pkg;
  // Source selected for the next fetch address
  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_TRAP = 2'd1,
    PC_RET  = 2'd2
  } pc_src_e;
endpackage

// File: rtl/ovf_adder.sv
module ovf_adder #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] result,
  output logic            ovf
);
  localparam int MSB = XLEN - 1;

  logic [XLEN:0] wide;   // top bit is the carry out, unused for overflow
  logic          same_sign;
  logic          flipped;

  always_comb begin
    wide      = {1'b0, a} + {1'b0, b};
    result    = wide[MSB:0];
    same_sign = (a[MSB] == b[MSB]);
    flipped   = (result[MSB] != a[MSB]);
    ovf       = same_sign && flipped;
  end

  logic unused_carry;
  assign unused_carry = wide[XLEN];
endmodule

// File: rtl/pc_redirect.sv
module pc_redirect
  import ovf_trap_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter logic [31:0] TRAP_VEC = 32'h8000_0180,
  parameter int          STEP     = 4
) (
  input  logic            trap,
  input  logic            eret_req,
  input  logic [XLEN-1:0] inst_addr,
  input  logic [XLEN-1:0] eret_target,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] VEC  = XLEN'(TRAP_VEC);
  localparam logic [XLEN-1:0] INCR = XLEN'(STEP);

  pc_src_e src;

  // The trap outranks the return request
  always_comb begin
    if (trap)          src = PC_TRAP;
    else if (eret_req) src = PC_RET;
    else               src = PC_SEQ;
  end

  always_comb begin
    unique case (src)
      PC_TRAP: next_pc = VEC;
      PC_RET:  next_pc = eret_target;
      default: next_pc = inst_addr + INCR;
    endcase
  end
endmodule

// File: rtl/epc_reg.sv
module epc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [XLEN-1:0] fault_addr,
  output logic [XLEN-1:0] epc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epc_q <= '0;
    else if (capture) epc_q <= fault_addr;
  end
endmodule

// File: rtl/ovf_trap_unit.sv
module ovf_trap_unit #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] TRAP_VEC = 32'h8000_0180,
  parameter int          STEP     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            add_valid,
  input  logic            trap_en,
  input  logic [XLEN-1:0] inst_addr,
  input  logic            eret_req,
  input  logic [XLEN-1:0] eret_target,
  output logic [XLEN-1:0] sum,
  output logic            wr_en,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] epc
);
  logic ovf;
  logic trap;

  ovf_adder #(.XLEN(XLEN)) u_add (
    .a      (op_a),
    .b      (op_b),
    .result (sum),
    .ovf    (ovf)
  );

  // Only a valid trapping add may trap
  assign trap  = add_valid && trap_en && ovf;
  assign wr_en = add_valid && !trap;

  pc_redirect #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC), .STEP(STEP)) u_pc (
    .trap        (trap),
    .eret_req    (eret_req),
    .inst_addr   (inst_addr),
    .eret_target (eret_target),
    .next_pc     (next_pc)
  );

  epc_reg #(.XLEN(XLEN)) u_epc (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (trap),
    .fault_addr (inst_addr),
    .epc_q      (epc)
  );
endmodule

// File: rtl/ovf_trap_unit_chk.sv
module ovf_trap_unit_chk #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] TRAP_VEC = 32'h8000_0180,
  parameter int          STEP     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic            add_valid,
  input logic            trap_en,
  input logic [XLEN-1:0] inst_addr,
  input logic            eret_req,
  input logic [XLEN-1:0] eret_target,
  input logic [XLEN-1:0] sum,
  input logic            wr_en,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] epc
);
  localparam int MSB = XLEN - 1;
  localparam logic [XLEN-1:0] VEC = XLEN'(TRAP_VEC);

  logic trap_seen;
  assign trap_seen = add_valid && trap_en && !wr_en;

  assert_trap_sign_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_seen |-> (op_a[MSB] == op_b[MSB]) && (sum[MSB] != op_a[MSB]));

  assert_no_carry_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && op_a[MSB] != op_b[MSB]) |-> wr_en);

  assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !add_valid |-> !wr_en);

  assert_nontrap_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && !trap_en) |-> wr_en);

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_seen |-> next_pc == VEC);

  assert_epc_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_seen |=> epc == $past(inst_addr));

  assert_epc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_seen |=> $stable(epc));

  assert_eret_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !trap_seen) |-> next_pc == eret_target);

  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eret_req && !trap_seen) |-> next_pc == inst_addr + XLEN'(STEP));

  assert_trap_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && trap_seen) |-> next_pc == VEC);
endmodule

bind ovf_trap_unit ovf_trap_unit_chk #(.XLEN(XLEN), .TRAP_VEC(TRAP_VEC), .STEP(STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .add_valid(add_valid),
  .trap_en(trap_en), .inst_addr(inst_addr), .eret_req(eret_req),
  .eret_target(eret_target), .sum(sum), .wr_en(wr_en), .next_pc(next_pc), .epc(epc)
);

// File: tb/ovf_trap_unit_test.sv
module ovf_trap_unit_test;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, inst_addr = '0, eret_target = '0;
  logic        add_valid = 1'b0, trap_en = 1'b0, eret_req = 1'b0;
  logic [31:0] sum, next_pc, epc;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ovf_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .add_valid(add_valid),
    .trap_en(trap_en), .inst_addr(inst_addr), .eret_req(eret_req),
    .eret_target(eret_target), .sum(sum), .wr_en(wr_en), .next_pc(next_pc), .epc(epc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // Drive at a falling edge, then let the combinational outputs settle
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic v, input logic te,
                       input logic [31:0] pc, input logic er, input logic [31:0] tgt);
    @(negedge clk);
    op_a = a; op_b = b; add_valid = v; trap_en = te;
    inst_addr = pc; eret_req = er; eret_target = tgt;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    drive(32'd0, 32'd0, 1'b0, 1'b0, 32'h0040_0000, 1'b0, 32'd0);
    eq("R8 epc after reset", epc, 32'd0);
    eq("R4 no write when idle", {31'd0, wr_en}, 32'd0);
    eq("R10 sequential pc", next_pc, 32'h0040_0004);
  endtask

  task automatic t_plain();
    drive(32'd5, 32'd7, 1'b1, 1'b1, 32'h0040_0010, 1'b0, 32'd0);
    eq("R1 sum 5+7", sum, 32'd12);
    eq("R4 write on clean add", {31'd0, wr_en}, 32'd1);
    eq("R10 next pc", next_pc, 32'h0040_0014);
    after_edge();
    eq("R8 epc hold after clean add", epc, 32'd0);
  endtask

  task automatic t_carry();
    drive(32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1, 32'h0040_0020, 1'b0, 32'd0);
    eq("R1 sum wraps", sum, 32'd0);
    eq("R3 carry -1+1 no trap", {31'd0, wr_en}, 32'd1);
    eq("R3 pc unchanged by carry", next_pc, 32'h0040_0024);
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 32'h0040_0028, 1'b0, 32'd0);
    eq("R3 mixed signs no trap", {31'd0, wr_en}, 32'd1);
    drive(32'h7FFF_FFFE, 32'd1, 1'b1, 1'b1, 32'h0040_002C, 1'b0, 32'd0);
    eq("R2 edge max no overflow", {31'd0, wr_en}, 32'd1);
    eq("R1 sum to max", sum, 32'h7FFF_FFFF);
    after_edge();
    eq("R8 epc hold after carry", epc, 32'd0);
  endtask

  task automatic t_pos_ovf();
    drive(32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1, 32'h0040_00B4, 1'b0, 32'd0);
    eq("R1 sum on overflow", sum, 32'h8000_0000);
    eq("R2 positive overflow suppresses write", {31'd0, wr_en}, 32'd0);
    eq("R6 vector on trap", next_pc, VEC);
    after_edge();
    eq("R7 epc is faulting address", epc, 32'h0040_00B4);
  endtask

  task automatic t_nontrap();
    drive(32'h7FFF_FFFF, 32'd1, 1'b1, 1'b0, 32'h0040_0200, 1'b0, 32'd0);
    eq("R5 nontrap writes", {31'd0, wr_en}, 32'd1);
    eq("R5 nontrap no redirect", next_pc, 32'h0040_0204);
    after_edge();
    eq("R8 epc hold on nontrap", epc, 32'h0040_00B4);
  endtask

  task automatic t_invalid();
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 32'h0040_0300, 1'b0, 32'd0);
    eq("R4 invalid no write", {31'd0, wr_en}, 32'd0);
    eq("R2 invalid no trap", next_pc, 32'h0040_0304);
    after_edge();
    eq("R8 epc hold on invalid", epc, 32'h0040_00B4);
  endtask

  task automatic t_eret();
    logic [31:0] ret;
    ret = epc + 32'd4;
    drive(32'd1, 32'd2, 1'b0, 1'b0, 32'h8000_01A0, 1'b1, ret);
    eq("R9 return target", next_pc, 32'h0040_00B8);
    after_edge();
    eq("R8 epc hold on return", epc, 32'h0040_00B4);
  endtask

  task automatic t_neg_prio();
    drive(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 32'h0040_0400, 1'b1, 32'h1234_5678);
    eq("R1 sum negative wrap", sum, 32'd0);
    eq("R2 negative overflow no write", {31'd0, wr_en}, 32'd0);
    eq("R11 trap beats return", next_pc, VEC);
    after_edge();
    eq("R11 epc captured with return", epc, 32'h0040_0400);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_plain();
    t_carry();
    t_pos_ovf();
    t_nontrap();
    t_invalid();
    t_eret();
    t_neg_prio();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule